// File: doc/BRIEF.md
# Event Flag and Interrupt Enable Register with Set/Clear Aliases

This block holds the event flags and interrupt enables of a bus-master serial peripheral in one 32-bit word. Hardware producers raise single-cycle pulses on eight event lines. Each pulse latches a sticky flag in the low byte. Software picks which flags may interrupt by setting enable bits in the byte above. Enable n sits eight positions above flag n. One interrupt line is raised while any flag has its enable set.

Software reaches the word at three addresses. A plain address loads every writable bit. A set alias ORs ones into the word. A clear alias removes ones from it. The aliases let software enable a group of events, or acknowledge exactly the flags it has just serviced, in one write and with no read-modify-write race. The usual acknowledge sequence is: read the word, mask the flags with the enables, then write that mask back through the clear alias.

The eight flag positions carry these meanings, from bit 7 down to bit 0: bus idle, data engine done, missing acknowledge from the addressed target, transfer longer than allowed, transfer ended early, arbitration lost, stop seen while addressed as a target, and addressed as a target. The block treats all eight alike.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset, all eight flags (bits 7:0) and all eight enables (bits 15:8) are zero, and `irqOut` is low.
- R2: A one on `evtPulse[n]` in a clock cycle sets flag n (bit n of the word) at that edge. The flag stays set until software clears or overwrites it.
- R3: A write to offset 0x00 loads bits 7:0 of the write data into the flags and bits 15:8 into the enables. An event pulse in the same cycle still sets its flag.
- R4: A write to offset 0x04 sets every flag or enable whose write-data bit is one. Bits written as zero keep their value.
- R5: A write to offset 0x08 clears every flag or enable whose write-data bit is one. Bits written as zero keep their value.
- R6: When an event pulse and a clear-alias write hit the same flag in the same cycle, the flag ends up set.
- R7: A read of offset 0x00, 0x04 or 0x08 returns `{16'h0000, enables, flags}`. Bits 31:16 always read as zero, and writes to them are ignored.
- R8: `irqOut` is the registered OR over n of (flag n AND enable n). It changes exactly one clock after the flags or enables change.
- R9: A write to any other offset changes nothing. A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | REG_W (32) | Write data |
| busRdData | output | REG_W (32) | Combinational read data for `busAddr` |
| evtPulse | input | NUM_EVT (8) | One-cycle event pulses from the hardware producers |
| irqOut | output | 1 | Interrupt request, registered |

## Verification
A flag that is wrongly kept or dropped shows up on `busRdData` in the cycle right after the edge that should have changed it. The same fault shows up on `irqOut` one cycle later, provided the matching enable is set. A wrong enable is visible only on the read port until a flag under it is raised. For that reason the bench raises flags both with enables on and with enables off. The bench runs a model of the word next to the design and compares both outputs on every clock. A decode or priority fault is therefore caught in the cycle of the faulty access.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // One strobe per kind of register access, decoded for the current cycle.
  typedef struct packed {
    logic loadAll;   // plain write: replace all writable bits
    logic setBits;   // set-alias write: OR the ones in
    logic clrBits;   // clear-alias write: remove the ones
    logic readHit;   // address falls on one of the three aliases
  } regStrobeT;

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BASE_OFF = 'h00,
  parameter int SET_OFF  = 'h04,
  parameter int CLR_OFF  = 'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobeT         strb
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_OFF);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFF);

  logic hitBase;
  logic hitSet;
  logic hitClr;

  assign hitBase = (busAddr == BASE_A);
  assign hitSet  = (busAddr == SET_A);
  assign hitClr  = (busAddr == CLR_A);

  always_comb begin
    strb.loadAll = busWrEn && hitBase;
    strb.setBits = busWrEn && hitSet;
    strb.clrBits = busWrEn && hitClr;
    strb.readHit = hitBase || hitSet || hitClr;
  end

  // R9: at most one kind of write is decoded in any cycle.
  assert_one_write_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadAll, strb.setBits, strb.clrBits}));

  // R9: no write strobe without a bus write.
  assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> !(strb.loadAll || strb.setBits || strb.clrBits));

endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [NUM_EVT-1:0] enableQ,
  output logic               irqOut
);

  localparam int ENA_LSB = NUM_EVT;

  logic [NUM_EVT-1:0] wrFlag;
  logic [NUM_EVT-1:0] wrEna;
  logic [NUM_EVT-1:0] statusNxt;
  logic [NUM_EVT-1:0] enableNxt;

  assign wrFlag = wrData[NUM_EVT-1:0];
  assign wrEna  = wrData[ENA_LSB +: NUM_EVT];

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic flagSw;
      logic enaSw;

      // Software view of this flag; the event pulse is ORed on top, so it wins.
      always_comb begin
        flagSw = statusQ[i];
        if (strb.loadAll)      flagSw = wrFlag[i];
        else if (strb.setBits) flagSw = statusQ[i] | wrFlag[i];
        else if (strb.clrBits) flagSw = statusQ[i] & ~wrFlag[i];
        statusNxt[i] = flagSw | evtPulse[i];
      end

      always_comb begin
        enaSw = enableQ[i];
        if (strb.loadAll)      enaSw = wrEna[i];
        else if (strb.setBits) enaSw = enableQ[i] | wrEna[i];
        else if (strb.clrBits) enaSw = enableQ[i] & ~wrEna[i];
        enableNxt[i] = enaSw;
      end

      // R2: a pulse always leaves its flag set.
      assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
        evtPulse[i] |=> statusQ[i]);

      // R6: a clear alias write loses against a pulse on the same bit.
      assert_evt_beats_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clrBits && wrFlag[i] && evtPulse[i]) |=> statusQ[i]);

      // R5: a clear with no pulse drops the flag.
      assert_clr_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clrBits && wrFlag[i] && !evtPulse[i]) |=> !statusQ[i]);

      // R4: a set alias write raises the enable.
      assert_set_ena_R4: assert property (@(posedge clk) disable iff (!rstN)
        (strb.setBits && wrEna[i]) |=> enableQ[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= statusNxt;
      enableQ <= enableNxt;
      irqOut  <= |(statusQ & enableQ);
    end
  end

  // R8: the interrupt follows the masked flags one cycle later.
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enableQ)) |=> irqOut);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & enableQ)) |=> !irqOut);

  // R4: enables move only on a register write.
  assert_ena_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadAll || strb.setBits || strb.clrBits) |=> $stable(enableQ));

endmodule

// File: rtl/evt_irq_reg.sv
module evt_irq_reg
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 32,
  parameter int NUM_EVT  = 8,
  parameter int BASE_OFF = 'h00,
  parameter int SET_OFF  = 'h04,
  parameter int CLR_OFF  = 'h08
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqOut
);

  localparam int USED_W = 2 * NUM_EVT;
  localparam int RSVD_W = REG_W - USED_W;

  regStrobeT          strb;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] enableQ;

  evt_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .BASE_OFF(BASE_OFF),
    .SET_OFF (SET_OFF),
    .CLR_OFF (CLR_OFF)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strb   (strb)
  );

  evt_irq_dp #(
    .REG_W  (REG_W),
    .NUM_EVT(NUM_EVT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .evtPulse(evtPulse),
    .statusQ (statusQ),
    .enableQ (enableQ),
    .irqOut  (irqOut)
  );

  assign busRdData = strb.readHit ? {{RSVD_W{1'b0}}, enableQ, statusQ} : '0;

  // R7: the reserved upper bits never read back as one.
  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[REG_W-1:USED_W] == '0);

  // R9: unmapped addresses read as zero.
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readHit |-> (busRdData == '0));

endmodule

// File: tb/test_evt_irq_reg.sv
module test_evt_irq_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  evtPulse = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;

  // Reference state: flags, enables and interrupt after the last edge.
  logic [7:0] mS = '0;
  logic [7:0] mE = '0;
  logic       mIrq = 1'b0;

  always #4 clk = ~clk;

  evt_irq_reg i_evt_irq_reg (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .evtPulse (evtPulse),
    .irqOut   (irqOut)
  );

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04 || a == 8'h08) return {16'h0000, mE, mS};
    return 32'h0;
  endfunction

  task automatic compare(input string tag);
    logic [31:0] er;
    er = expRead(busAddr);
    total++;
    if (busRdData !== er) begin
      bad++;
      $display("FAIL %s rdData actual=%h expected=%h", tag, busRdData, er);
    end
    total++;
    if (irqOut !== mIrq) begin
      bad++;
      $display("FAIL %s irqOut actual=%b expected=%b", tag, irqOut, mIrq);
    end
  endtask

  // One cycle of stimulus followed by a comparison after the edge.
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic [7:0] ev, input string tag);
    logic [7:0] nS;
    logic [7:0] nE;
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = d; evtPulse = ev;
    @(posedge clk);
    nS = mS; nE = mE;
    if (we) begin
      case (a)
        8'h00: begin nS = d[7:0]; nE = d[15:8]; end
        8'h04: begin nS = mS | d[7:0]; nE = mE | d[15:8]; end
        8'h08: begin nS = mS & ~d[7:0]; nE = mE & ~d[15:8]; end
        default: ;
      endcase
    end
    mIrq = |(mS & mE);
    mS = nS | ev;
    mE = nE;
    #1;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    step(8'h00, 1'b0, 32'h0, 8'h00, "R1 idle after reset");
    // R2: events raise sticky flags, enables still off so no interrupt
    step(8'h00, 1'b0, 32'h0, 8'h05, "R2 pulse bits 0,2");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R2 sticky");
    step(8'h00, 1'b0, 32'h0, 8'h80, "R2 pulse bit 7");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 no irq while disabled");
    // R4: set enables through the set alias
    step(8'h04, 1'b1, 32'h0000_0400, 8'h00, "R4 set enable 2");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 irq one cycle after enable");
    step(8'h04, 1'b1, 32'h0000_6810, 8'h00, "R4 set mixed");
    // R5: clear flags through the clear alias
    step(8'h08, 1'b1, 32'h0000_0004, 8'h00, "R5 clear flag 2");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 irq drops a cycle later");
    step(8'h08, 1'b1, 32'h0000_4000, 8'h00, "R5 clear enable 6");
    // R6: pulse and clear on the same flag
    step(8'h00, 1'b0, 32'h0, 8'h08, "R6 prepare flag 3");
    step(8'h08, 1'b1, 32'h0000_0008, 8'h08, "R6 event beats clear");
    step(8'h08, 1'b1, 32'h0000_0008, 8'h00, "R6 later clear works");
    // R3 and R7: base write loads, upper half ignored
    step(8'h00, 1'b1, 32'hFFFF_A55A, 8'h00, "R3 R7 base load");
    step(8'h04, 1'b0, 32'h0, 8'h00, "R7 read via set alias");
    step(8'h08, 1'b0, 32'h0, 8'h00, "R7 read via clear alias");
    step(8'h00, 1'b1, 32'h0000_0300, 8'h41, "R3 load with event");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 after load");
    // R9: unmapped writes and reads
    step(8'h0C, 1'b1, 32'hFFFF_FFFF, 8'h00, "R9 unmapped write");
    step(8'h10, 1'b0, 32'h0, 8'h00, "R9 unmapped read");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R9 state intact");
    // acknowledge sequence: read, mask, clear
    step(8'h04, 1'b1, 32'h0000_FF00, 8'hFF, "R4 enable all with events");
    step(8'h08, 1'b1, 32'h0000_00FF, 8'h10, "R6 ack all but new event");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 irq on remaining flag");
    step(8'h08, 1'b1, 32'h0000_FFFF, 8'h00, "R5 clear everything");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R8 quiet");
    step(8'h00, 1'b0, 32'h0, 8'h00, "R1 final idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule